// File: doc/BRIEF.md
# Variable-width quadratic residue generator

This block is a cryptographic pseudo-random bit source. It holds a modulus Q and a state X, and it keeps replacing the state with X·X mod Q. After each squaring it sends out the lowest floor(log2 w) bits of the new state as a serial stream, where w is the active operand width. The width is picked at load time in 64-bit slices, up to the parameter `MAX_W`. Register slices above the active width are never clocked, so they stay idle before and during every squaring.

Software loads the modulus, the seed and the width select with one load pulse. Holding `run` high then lets the generator square repeatedly. Each result bit is presented with `out_valid` and leaves on an `out_ready` handshake. The squarer is an iterative left-to-right interleaved modular multiplier. Each cycle it retires two multiplier bits, so a squaring takes w/2 cycles, and it keeps the plain binary result with no number-system conversion. A new squaring begins only after every bit of the previous one has been accepted. A load with an unusable seed or modulus raises an error flag and leaves the generator stopped.

Top module: `qrg_top`

## Requirements
- R1: After reset, `out_valid`, `busy` and `load_err` are low, and no squaring starts and no bit appears until a valid load has been made, even with `run` and `out_ready` high.
- R2: A load is rejected when the masked seed is zero, when bit w-1 of the modulus is clear, or when the masked seed is not below the masked modulus. In that case `load_err` is high from the cycle after the load, and no squaring runs and no bit appears until the next load.
- R3: An accepted load clears `load_err` in the next cycle and sets the state to the masked seed. Each squaring then replaces the state with state² mod Q over the active width.
- R4: After each squaring, floor(log2 w) bits of the new state are presented, bit 0 first. There are 6 bits for w=64 and 7 bits for w=128.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value.
- R6: `width_sel` = k selects w = 64·(k+1), clamped to `MAX_W`. Each squaring keeps `busy` high for exactly w/2 cycles. With `run` and `out_ready` held high, `out_valid` is low for exactly w/2+2 cycles between consecutive bit groups.
- R7: `width_sel` is sampled only in a load cycle. Changing it at any other time has no effect on the stream.
- R8: No squaring starts while `run` is low. A squaring already in progress still completes, and its bits are delivered.
- R9: A load aborts any squaring in progress and discards undelivered bits, so `busy` and `out_valid` are low in the next cycle. A handshake that falls in the load cycle still transfers its bit.
- R10: Bits of `mod_in` and `seed_in` at or above the selected width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load pulse for modulus, seed and width |
| mod_in | input | MAX_W | Modulus Q |
| seed_in | input | MAX_W | Initial state |
| width_sel | input | SW | Width select, w = 64·(value+1) |
| run | input | 1 | Allows new squarings to start |
| out_ready | input | 1 | Sink accepts the presented bit |
| out_bit | output | 1 | Current random bit |
| out_valid | output | 1 | `out_bit` is valid |
| busy | output | 1 | A squaring is in progress |
| load_err | output | 1 | Last load was rejected |

## Verification
Two events can land in the same cycle: a load, and an output handshake on the first bit of a fresh group. The bench holds `out_ready` low until a group is presented, then raises `out_ready` and `load` together. The scoreboard must see exactly that one old bit transferred, `out_valid` must be low one cycle later, and the stream that follows must match the squarings of the new seed. A second collision is a load that lands mid-squaring. It is judged by `busy` dropping at once and the next squaring using the new operands.

// File: rtl/qrg_pkg.sv
package qrg_pkg;

    localparam int SLICE_W = 64;

    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_ARMED = 2'd1,
        GS_FAULT = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic seed_zero;
        logic top_clear;
        logic seed_ge;
    } load_chk_t;

    // width select code -> number of active slices, clamped
    function automatic int sel_to_slices(int sel, int nsl);
        if (sel + 1 > nsl) return nsl;
        return sel + 1;
    endfunction

    // index of the highest set bit
    function automatic int floor_log2(int v);
        int r;
        r = 0;
        for (int i = 0; i < 31; i++) begin
            if ((v >> i) != 0) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/qrg_slice_ctl.sv
module qrg_slice_ctl
    import qrg_pkg::*;
#(
    parameter int MAX_W = 128,
    parameter int NSL   = MAX_W / SLICE_W,
    parameter int NSW   = $clog2(NSL + 1)
) (
    input  logic [NSW-1:0]   n_act,
    output logic [NSL-1:0]   slice_en,
    output logic [MAX_W-1:0] bit_mask
);

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        assign slice_en[g] = (g < int'(n_act));
        assign bit_mask[g*SLICE_W +: SLICE_W] = {SLICE_W{slice_en[g]}};
    end

endmodule

// File: rtl/qrg_modmul.sv
module qrg_modmul
    import qrg_pkg::*;
#(
    parameter int MAX_W = 128,
    parameter int NSL   = MAX_W / SLICE_W,
    parameter int NSW   = $clog2(NSL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [NSW-1:0]   n_act,
    input  logic [MAX_W-1:0] x_in,
    input  logic [MAX_W-1:0] q_in,
    output logic             busy,
    output logic             done,
    output logic [MAX_W-1:0] result
);

    localparam int IT_MAX = MAX_W / 2;
    localparam int CW     = $clog2(IT_MAX + 1);
    localparam int EW     = MAX_W + 2;

    logic [NSL-1:0]   slice_en;
    logic [MAX_W-1:0] bit_mask;
    logic [MAX_W-1:0] p_raw;
    logic [MAX_W-1:0] p_q;
    logic [MAX_W-1:0] p_half;
    logic [MAX_W-1:0] p_next;
    logic [MAX_W-1:0] y_r;
    logic [CW-1:0]    cnt_r;
    logic             busy_r;
    logic             done_r;

    qrg_slice_ctl #(.MAX_W(MAX_W), .NSL(NSL), .NSW(NSW)) u_slices (
        .n_act    (n_act),
        .slice_en (slice_en),
        .bit_mask (bit_mask)
    );

    // one radix-2 step: 2p + b*x, then bring back below q
    function automatic logic [MAX_W-1:0] red_step(
        input logic [MAX_W-1:0] p,
        input logic [MAX_W-1:0] x,
        input logic [MAX_W-1:0] q,
        input logic             b
    );
        logic [EW-1:0] t;
        logic [EW-1:0] q1;
        logic [EW-1:0] q2;
        q1 = EW'(q);
        q2 = q1 << 1;
        t  = (EW'(p) << 1) + (b ? EW'(x) : '0);
        if (t >= q2)      t = t - q2;
        else if (t >= q1) t = t - q1;
        return t[MAX_W-1:0];
    endfunction

    assign p_q    = p_raw & bit_mask;
    assign p_half = red_step(p_q, x_in, q_in, y_r[MAX_W-1]);
    assign p_next = red_step(p_half, x_in, q_in, y_r[MAX_W-2]) & bit_mask;

    // accumulator slices: only slices inside the active width are clocked
    for (genvar g = 0; g < NSL; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                p_raw[g*SLICE_W +: SLICE_W] <= '0;
            end else if (slice_en[g] && !abort) begin
                if (start)
                    p_raw[g*SLICE_W +: SLICE_W] <= '0;
                else if (busy_r)
                    p_raw[g*SLICE_W +: SLICE_W] <= p_next[g*SLICE_W +: SLICE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_r    <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            done_r <= 1'b0;
        end else if (abort) begin
            busy_r <= 1'b0;
            done_r <= 1'b0;
        end else if (start) begin
            y_r    <= x_in << ((NSL - int'(n_act)) * SLICE_W);
            cnt_r  <= CW'(int'(n_act) * (SLICE_W / 2));
            busy_r <= 1'b1;
            done_r <= 1'b0;
        end else if (busy_r) begin
            y_r   <= y_r << 2;
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CW'(1)) begin
                busy_r <= 1'b0;
                done_r <= 1'b1;
            end
        end else begin
            done_r <= 1'b0;
        end
    end

    assign busy   = busy_r;
    assign done   = done_r;
    assign result = p_q;

endmodule

// File: rtl/qrg_serializer.sv
module qrg_serializer #(
    parameter int OB_MAX = 8,
    parameter int OBC    = $clog2(OB_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              fill,
    input  logic [OB_MAX-1:0] fill_bits,
    input  logic [OBC-1:0]    fill_cnt,
    input  logic              ready,
    output logic              out_bit,
    output logic              out_valid,
    output logic              empty
);

    logic [OB_MAX-1:0] sr_r;
    logic [OBC-1:0]    cnt_r;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr_r  <= '0;
            cnt_r <= '0;
        end else if (fill) begin
            sr_r  <= fill_bits;
            cnt_r <= fill_cnt;
        end else if (cnt_r != '0 && ready) begin
            sr_r  <= sr_r >> 1;
            cnt_r <= cnt_r - 1'b1;
        end
    end

    assign out_bit   = sr_r[0];
    assign out_valid = (cnt_r != '0);
    assign empty     = (cnt_r == '0);

endmodule

// File: rtl/qrg_top.sv
module qrg_top
    import qrg_pkg::*;
#(
    parameter int MAX_W = 128,
    parameter int NSL   = MAX_W / SLICE_W,
    parameter int SW    = (NSL > 1) ? $clog2(NSL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAX_W-1:0] mod_in,
    input  logic [MAX_W-1:0] seed_in,
    input  logic [SW-1:0]    width_sel,
    input  logic             run,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_valid,
    output logic             busy,
    output logic             load_err
);

    localparam int NSW    = $clog2(NSL + 1);
    localparam int OB_MAX = $clog2(MAX_W + 1);
    localparam int OBC    = $clog2(OB_MAX + 1);

    gen_state_e       state_r;
    logic [NSW-1:0]   n_sel;
    logic [NSW-1:0]   n_act_r;
    logic [MAX_W-1:0] mask_sel;
    logic [MAX_W-1:0] mod_m;
    logic [MAX_W-1:0] seed_m;
    logic [MAX_W-1:0] mod_r;
    logic [MAX_W-1:0] x_r;
    load_chk_t        chk;
    logic             load_bad;
    logic             mul_start;
    logic             mul_busy;
    logic             mul_done;
    logic [MAX_W-1:0] mul_res;
    logic             ser_empty;
    logic [OBC-1:0]   ob_cnt;

    // width select decoded for the operands being loaded
    assign n_sel = NSW'(sel_to_slices(int'(width_sel), NSL));

    for (genvar g = 0; g < NSL; g++) begin : g_selmask
        assign mask_sel[g*SLICE_W +: SLICE_W] = {SLICE_W{g < int'(n_sel)}};
    end

    assign mod_m  = mod_in & mask_sel;
    assign seed_m = seed_in & mask_sel;

    always_comb begin
        chk.seed_zero = (seed_m == '0);
        chk.top_clear = !mod_m[int'(n_sel) * SLICE_W - 1];
        chk.seed_ge   = (seed_m >= mod_m);
    end
    assign load_bad = |chk;

    assign mul_start = (state_r == GS_ARMED) && run && !mul_busy && !mul_done
                       && ser_empty && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_r <= GS_IDLE;
            n_act_r <= NSW'(1);
            mod_r   <= '0;
            x_r     <= '0;
        end else if (load) begin
            n_act_r <= n_sel;
            mod_r   <= mod_m;
            x_r     <= seed_m;
            state_r <= load_bad ? GS_FAULT : GS_ARMED;
        end else if (mul_done) begin
            x_r <= mul_res;
        end
    end

    qrg_modmul #(.MAX_W(MAX_W), .NSL(NSL), .NSW(NSW)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .start  (mul_start),
        .abort  (load),
        .n_act  (n_act_r),
        .x_in   (x_r),
        .q_in   (mod_r),
        .busy   (mul_busy),
        .done   (mul_done),
        .result (mul_res)
    );

    assign ob_cnt = OBC'(floor_log2(int'(n_act_r) * SLICE_W));

    qrg_serializer #(.OB_MAX(OB_MAX), .OBC(OBC)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .clear     (load),
        .fill      (mul_done),
        .fill_bits (mul_res[OB_MAX-1:0]),
        .fill_cnt  (ob_cnt),
        .ready     (out_ready),
        .out_bit   (out_bit),
        .out_valid (out_valid),
        .empty     (ser_empty)
    );

    assign busy     = mul_busy;
    assign load_err = (state_r == GS_FAULT);

endmodule

// File: rtl/qrg_checker.sv
module qrg_checker
    import qrg_pkg::*;
#(
    parameter int MAX_W = 128,
    parameter int SW    = 1
) (
    input logic          clk,
    input logic          rst,
    input logic          load,
    input logic [SW-1:0] width_sel,
    input logic          run,
    input logic          out_ready,
    input logic          out_bit,
    input logic          out_valid,
    input logic          busy,
    input logic          load_err
);

    localparam int NSL = MAX_W / SLICE_W;
    localparam int BCW = $clog2(MAX_W / 2 + 2);

    logic [BCW-1:0] bcnt;
    int             w_sl;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt <= '0;
            w_sl <= 1;
        end else begin
            bcnt <= busy ? bcnt + 1'b1 : '0;
            if (load) w_sl <= sel_to_slices(int'(width_sel), NSL);
        end
    end

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !load |=> out_valid && $stable(out_bit));

    assert_load_flush_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> !out_valid && !busy);

    assert_fault_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        load_err |-> !busy && !out_valid);

    assert_run_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !run && !busy |=> !busy);

    assert_square_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && !$past(load) |-> int'(bcnt) == w_sl * (SLICE_W / 2));

    assert_group_after_square_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> !busy);

endmodule

bind qrg_top qrg_checker #(.MAX_W(MAX_W), .SW(SW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .width_sel (width_sel),
    .run       (run),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_valid (out_valid),
    .busy      (busy),
    .load_err  (load_err)
);

// File: tb/qrg_top_test.sv
`timescale 1ns/1ps
module qrg_top_test;

    localparam int MAX_W = 128;
    localparam int SW    = 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load = 1'b0;
    logic [MAX_W-1:0] mod_in = '0;
    logic [MAX_W-1:0] seed_in = '0;
    logic [SW-1:0]    width_sel = '0;
    logic             run = 1'b0;
    logic             out_ready = 1'b0;
    logic             out_bit;
    logic             out_valid;
    logic             busy;
    logic             load_err;

    always #2 clk = ~clk;

    qrg_top #(.MAX_W(MAX_W)) uut (
        .clk(clk), .rst(rst), .load(load), .mod_in(mod_in), .seed_in(seed_in),
        .width_sel(width_sel), .run(run), .out_ready(out_ready),
        .out_bit(out_bit), .out_valid(out_valid), .busy(busy), .load_err(load_err)
    );

    int               n_cmp = 0;
    int               n_bad = 0;
    bit               done_flag = 1'b0;
    string            tag = "R1";
    bit               exp_q[$];
    logic [MAX_W-1:0] mdl_x;
    logic [MAX_W-1:0] mdl_q;
    int               mdl_w;
    bit               chk_stall = 1'b0;
    logic             st_pend = 1'b0;
    logic             st_bit = 1'b0;

    localparam logic [63:0]  Q64A  = 64'hE3C5_9A17_2B6D_48F1;
    localparam logic [63:0]  S64A  = 64'h5A3C_96E1_0F2D_7B49;
    localparam logic [63:0]  Q64B  = 64'hB7D3_1E59_C2A4_6F8B;
    localparam logic [63:0]  S64B  = 64'h2C9E_7B31_D5A8_4F67;
    localparam logic [127:0] Q128  = 128'hD1B5_4A32_8C7E_F096_3A5D_C1E7_29B4_8F63;
    localparam logic [127:0] S128  = 128'h6E2F_A13C_5B87_D490_1C6A_E3F5_72B8_9D05;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [MAX_W-1:0] ref_sq(input logic [MAX_W-1:0] x,
                                                input logic [MAX_W-1:0] q);
        logic [2*MAX_W-1:0] prod;
        logic [2*MAX_W-1:0] rem;
        prod = {{MAX_W{1'b0}}, x} * {{MAX_W{1'b0}}, x};
        rem  = prod % {{MAX_W{1'b0}}, q};
        return rem[MAX_W-1:0];
    endfunction

    task automatic set_model(input logic [MAX_W-1:0] m, input logic [MAX_W-1:0] s,
                             input int sel);
        logic [MAX_W-1:0] msk;
        mdl_w = (sel + 1) * 64;
        if (mdl_w > MAX_W) mdl_w = MAX_W;
        for (int i = 0; i < MAX_W; i++) msk[i] = (i < mdl_w);
        mdl_q = m & msk;
        mdl_x = s & msk;
    endtask

    task automatic push_groups(input int n);
        int nb;
        nb = 0;
        while ((1 << (nb + 1)) <= mdl_w) nb++;
        for (int g = 0; g < n; g++) begin
            mdl_x = ref_sq(mdl_x, mdl_q);
            for (int i = 0; i < nb; i++) exp_q.push_back(mdl_x[i]);
        end
    endtask

    task automatic do_load(input logic [MAX_W-1:0] m, input logic [MAX_W-1:0] s,
                           input int sel);
        mod_in    = m;
        seed_in   = s;
        width_sel = SW'(sel);
        load      = 1'b1;
        set_model(m, s, sel);
        tick();
        load = 1'b0;
    endtask

    task automatic drain(input string req);
        int c;
        c = 0;
        while (exp_q.size() != 0 && c < 3000) begin
            tick();
            c++;
        end
        check(exp_q.size() == 0, req, "expected bits left undelivered", exp_q.size(), 0);
    endtask

    task automatic quiet_window(input string req, input int cycles);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (busy || out_valid) seen++;
        end
        check(seen == 0, req, "cycles with busy or out_valid", seen, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (chk_stall && st_pend)
                check(out_valid && out_bit == st_bit, "R5", "held bit under stall",
                      {out_valid, out_bit}, {1'b1, st_bit});
            st_pend = out_valid && !out_ready && !load;
            st_bit  = out_bit;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, tag, "unexpected output bit", out_bit, -1);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(out_bit == e, tag, "stream bit", out_bit, e);
                end
            end
        end
    end

    initial begin
        #(4 * 190000);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        int cnt;
        logic [7:0] lf;

        repeat (4) tick();
        rst = 1'b0;
        tick();

        // R1: reset state and no activity without a load
        tag = "R1";
        check(!out_valid && !busy && !load_err, "R1", "reset outputs",
              {out_valid, busy, load_err}, 0);
        run = 1'b1;
        out_ready = 1'b1;
        quiet_window("R1", 40);

        // R4 / R6: 64-bit stream and timing
        tag = "R4";
        do_load({64'h0, Q64A}, {64'h0, S64A}, 0);
        push_groups(4);
        while (!busy) tick();
        cnt = 0;
        while (busy) begin cnt++; tick(); end
        check(cnt == 32, "R6", "busy cycles at w=64", cnt, 32);
        while (!out_valid) tick();
        while (out_valid) tick();
        cnt = 0;
        while (!out_valid) begin cnt++; tick(); end
        check(cnt == 34, "R6", "gap cycles at w=64", cnt, 34);
        drain("R4");
        out_ready = 1'b0;

        // R3 / R6: 128-bit stream
        tag = "R3";
        do_load(Q128, S128, 1);
        check(!load_err, "R3", "load_err after good load", load_err, 0);
        out_ready = 1'b1;
        push_groups(3);
        while (!busy) tick();
        cnt = 0;
        while (busy) begin cnt++; tick(); end
        check(cnt == 64, "R6", "busy cycles at w=128", cnt, 64);
        while (!out_valid) tick();
        while (out_valid) tick();
        cnt = 0;
        while (!out_valid) begin cnt++; tick(); end
        check(cnt == 66, "R6", "gap cycles at w=128", cnt, 66);
        drain("R3");
        out_ready = 1'b0;

        // R5: irregular ready pattern
        tag = "R5";
        do_load(Q128, {64'h0, S64B}, 1);
        push_groups(3);
        chk_stall = 1'b1;
        lf = 8'hA5;
        cnt = 0;
        while (exp_q.size() != 0 && cnt < 4000) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            out_ready = lf[0];
            tick();
            cnt++;
        end
        check(exp_q.size() == 0, "R5", "bits left under stalls", exp_q.size(), 0);
        out_ready = 1'b0;
        tick();
        chk_stall = 1'b0;

        // R7: width change outside a load is ignored
        tag = "R7";
        do_load({64'h0, Q64B}, {64'h0, S64B}, 0);
        width_sel = 1'b1;
        out_ready = 1'b1;
        push_groups(3);
        drain("R7");
        out_ready = 1'b0;

        // R10: upper operand bits ignored
        tag = "R10";
        do_load({64'hFFFF_0000_1234_ABCD, Q64A}, {64'h9876_5432_DEAD_BEEF, S64B}, 0);
        check(!load_err, "R10", "load_err with upper garbage", load_err, 0);
        out_ready = 1'b1;
        push_groups(3);
        drain("R10");
        out_ready = 1'b0;

        // R2: rejected loads
        tag = "R2";
        do_load({64'h0, Q64A}, 128'h0, 0);
        check(load_err, "R2", "zero seed flagged", load_err, 1);
        out_ready = 1'b1;
        quiet_window("R2", 60);
        do_load({64'h0, 64'h7FD3_1E59_C2A4_6F8B}, {64'h0, S64A}, 0);
        check(load_err, "R2", "modulus top bit clear flagged", load_err, 1);
        quiet_window("R2", 60);
        do_load({64'h0, Q64A}, {64'h0, Q64A}, 0);
        check(load_err, "R2", "seed not below modulus flagged", load_err, 1);
        quiet_window("R2", 60);
        do_load({64'h0, Q64A}, {64'h0, S64A}, 0);
        check(!load_err, "R3", "good load clears error", load_err, 0);

        // R8: run gating
        tag = "R8";
        run = 1'b0;
        do_load({64'h0, Q64B}, {64'h0, S64A}, 0);
        quiet_window("R8", 60);
        run = 1'b1;
        while (!busy) tick();
        run = 1'b0;
        push_groups(1);
        drain("R8");
        quiet_window("R8", 80);

        // R9: load mid-squaring aborts it
        tag = "R9";
        run = 1'b1;
        do_load(Q128, S128, 1);
        while (!busy) tick();
        repeat (5) tick();
        do_load({64'h0, Q64A}, {64'h0, S64B}, 0);
        check(!busy && !out_valid, "R9", "abort clears busy/valid",
              {busy, out_valid}, 0);
        push_groups(2);
        drain("R9");

        // R9: load in the same cycle as a handshake
        out_ready = 1'b0;
        do_load({64'h0, Q64B}, {64'h0, S64A}, 0);
        push_groups(1);
        while (!out_valid) tick();
        mod_in    = {64'h0, Q64A};
        seed_in   = {64'h0, S64A};
        width_sel = 1'b0;
        load      = 1'b1;
        out_ready = 1'b1;
        tick();
        load = 1'b0;
        check(exp_q.size() == 5, "R9", "old bits left after collision edge",
              exp_q.size(), 5);
        check(!out_valid && !busy, "R9", "collision clears stream",
              {out_valid, busy}, 0);
        exp_q.delete();
        set_model({64'h0, Q64A}, {64'h0, S64A}, 0);
        push_groups(2);
        drain("R9");

        run = 1'b0;
        out_ready = 1'b0;
        repeat (4) tick();
        finish_run();
    end

endmodule